// File: doc/BRIEF.md
# Multi-DAC Voltage-Set Interpolating Sequencer

This block feeds a bank of serial four-channel DAC chips from voltage sets held in an external set memory. Each set holds one 16-bit code for every output channel. In static mode the block reads one set, sends it to every chip and latches it. It then stops, and no serial clock edge leaves the block until the next start.

In shuttling mode the block first sends the start set exactly. It then walks toward each following set in turn, up to the last set. On every update each channel moves toward the current target by a programmable step size. The last move is clamped so that it lands exactly on the target. When every channel has reached the target, the walk moves on to the next set. Updates are spaced by a programmable period in system clocks, and one update always carries a full frame to every chip.

All chips get their data on separate lines at the same time. The chips share one serial clock, which is the system clock divided down, and one latch line. During an update the block reads the set memory one channel per cycle, with a read latency of one cycle. It passes each word through a single stepping unit and keeps the resulting codes in a register bank. It then shifts that bank out.

Top module: `vset_sequencer`

## Requirements
- R1: After reset, `busy`, `sclk`, `latch` and every `sdata` bit are low.
- R2: The set memory is read with `mem_set` = set index and `mem_chan` = channel index. The data arrives on `mem_rdata` one clock later. Chip c carries channels 4c to 4c+3.
- R3: A frame sends 4 words of 24 bits to each chip, channel 0 first and MSB first. Each word is 6 zero bits, then the 2-bit channel number within the chip, then the 16-bit code. `sdata` is stable when `sclk` rises, and each frame has exactly 96 rising `sclk` edges.
- R4: After the last bit, `latch` is high for 4 system clocks while `sclk` is low. There is one latch pulse per frame.
- R5: With `shuttle` = 0, a start sends exactly one frame, holding the codes of `first_set`, and then returns to idle. A shuttle whose `last_set` is not above `first_set` also sends a single frame.
- R6: In shuttling mode the first frame holds `first_set` exactly. Each later frame moves every channel toward the codes of the current target set by `step_size`, and the target starts at `first_set`+1.
- R7: A channel that is within `step_size` of its target is set exactly to the target, never past it.
- R8: A `step_size` of 0 makes each frame jump straight to the target set.
- R9: The target set advances after the frame in which all channels equal it. The run ends after the frame in which all channels equal `last_set`.
- R10: The rising edges of consecutive `latch` pulses in a run are exactly `rate_div` clocks apart when `rate_div` is at least the update time. They are never closer together than one frame of serial clocking (96 × 2 × SCLK_HALF clocks).
- R11: While `busy` is low, `sclk` does not toggle, and `latch` and `sdata` stay low.
- R12: A `start` pulse while `busy` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| shuttle | input | 1 | 1 = shuttling walk, 0 = static load |
| first_set | input | SET_AW | First set index |
| last_set | input | SET_AW | Last set index of a shuttle |
| step_size | input | DW | Per-update step; 0 = jump |
| rate_div | input | RATE_W | Update period in system clocks |
| mem_set | output | SET_AW | Set memory read: set index |
| mem_chan | output | $clog2(N_CHIPS*4) | Set memory read: channel index |
| mem_rdata | input | DW | Set memory read data, one cycle latency |
| busy | output | 1 | Sequence in progress |
| sclk | output | 1 | Shared serial clock, low when idle |
| latch | output | 1 | Shared latch pulse |
| sdata | output | N_CHIPS | Serial data, one line per chip |

## Verification
The hardest situation to reach is the clamped final step. A channel must sit less than one step from its target while other channels still need more steps, and the walk must then roll over into the next set. The stimulus sets up stored sets whose codes span from all-zeros to all-ones, mixed with scattered values. It uses step sizes that do not divide the distances, so every shuttle ends in clamped moves on some channels and full moves on others. A second start pulse is injected in the middle of a frame to show that it is ignored.

// File: rtl/vsq_pkg.sv
// Shared state encodings for the voltage-set sequencer.
package vsq_pkg;
    typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_SHIFT, SQ_WAIT} seq_state_t;
    typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_LATCH} tx_state_t;
endpackage

// File: rtl/vsq_stepper.sv
// Single-channel interpolation step: moves cur toward tgt by step, clamped
// so it never passes tgt. Assumes unsigned codes; jump forces nxt = tgt.
module vsq_stepper #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] tgt,
    input  logic [DW-1:0] step,
    input  logic          jump,
    output logic [DW-1:0] nxt,
    output logic          at_tgt
);
    // Compute the clamped next code.
    always_comb begin
        if (jump || cur == tgt)
            nxt = tgt;
        else if (tgt > cur)
            nxt = ((tgt - cur) <= step) ? tgt : cur + step;
        else
            nxt = ((cur - tgt) <= step) ? tgt : cur - step;
        at_tgt = (nxt == tgt);
    end
endmodule

// File: rtl/vsq_serial.sv
// Frame shifter: sends CH_PER_CHIP words per chip in parallel on one data line
// per chip, under a shared divided clock, then raises a shared latch. Assumes
// vals is held stable from go until done. Clock is held low when idle.
module vsq_serial
    import vsq_pkg::*;
#(
    parameter int N_CHIPS     = 25,
    parameter int CH_PER_CHIP = 4,
    parameter int DW          = 16,
    parameter int WORD_BITS   = 24,
    parameter int SCLK_HALF   = 2,
    parameter int LATCH_CYC   = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                go,
    input  logic [N_CHIPS*CH_PER_CHIP*DW-1:0]   vals,
    output logic                                sclk,
    output logic                                latch,
    output logic [N_CHIPS-1:0]                  sdata,
    output logic                                done
);
    localparam int CPC_AW  = $clog2(CH_PER_CHIP);
    localparam int BIT_AW  = $clog2(WORD_BITS);
    localparam int DIV_AW  = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int LAT_AW  = $clog2(LATCH_CYC + 1);
    localparam int HDR_PAD = WORD_BITS - DW - CPC_AW;

    tx_state_t         st;
    logic [DIV_AW-1:0] div_q;
    logic [CPC_AW-1:0] w_q;
    logic [BIT_AW-1:0] b_q;
    logic [LAT_AW-1:0] lcnt;
    logic              sclk_q, lat_q, done_q;
    logic              half_end;

    assign half_end = (div_q == DIV_AW'(SCLK_HALF - 1));

    // Bit sequencing, clock division and latch pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= TX_IDLE; div_q <= '0; w_q <= '0; b_q <= '0; lcnt <= '0;
            sclk_q <= 1'b0; lat_q <= 1'b0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                TX_IDLE: if (go) begin
                    st <= TX_SHIFT; div_q <= '0; w_q <= '0; b_q <= '0; sclk_q <= 1'b0;
                end
                TX_SHIFT: if (half_end) begin
                    div_q <= '0;
                    if (!sclk_q) sclk_q <= 1'b1;
                    else begin
                        sclk_q <= 1'b0;
                        if (b_q == BIT_AW'(WORD_BITS - 1)) begin
                            b_q <= '0;
                            if (w_q == CPC_AW'(CH_PER_CHIP - 1)) begin
                                st <= TX_LATCH; lat_q <= 1'b1; lcnt <= '0;
                            end else w_q <= w_q + 1'b1;
                        end else b_q <= b_q + 1'b1;
                    end
                end else div_q <= div_q + 1'b1;
                TX_LATCH: if (lcnt == LAT_AW'(LATCH_CYC - 1)) begin
                    lat_q <= 1'b0; st <= TX_IDLE; done_q <= 1'b1;
                end else lcnt <= lcnt + 1'b1;
                default: st <= TX_IDLE;
            endcase
        end
    end

    assign sclk  = sclk_q;
    assign latch = lat_q;
    assign done  = done_q;

    // Per-chip word assembly and MSB-first bit selection.
    for (genvar c = 0; c < N_CHIPS; c++) begin : g_chip
        logic [DW-1:0]        code;
        logic [WORD_BITS-1:0] word;
        always_comb begin
            code     = vals[(c*CH_PER_CHIP + int'(w_q))*DW +: DW];
            word     = {{HDR_PAD{1'b0}}, w_q, code};
            sdata[c] = (st == TX_SHIFT) ? word[BIT_AW'(WORD_BITS - 1) - b_q] : 1'b0;
        end
    end

    AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q |-> !sclk_q);  // R4
    AST_LATCH_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_q) |-> $past(st) == TX_SHIFT);  // R4
    AST_TX_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        st == TX_IDLE |-> !sclk_q && !lat_q);  // R11
endmodule

// File: rtl/vset_sequencer.sv
// Voltage-set sequencer top: reads a set from memory one channel per cycle
// through a shared stepper into a code bank, ships the bank as one frame,
// and repeats at the programmed period until the last set is reached.
// Assumes a set memory with one cycle read latency.
module vset_sequencer
    import vsq_pkg::*;
#(
    parameter int N_CHIPS     = 25,
    parameter int CH_PER_CHIP = 4,
    parameter int DW          = 16,
    parameter int SET_AW      = 5,
    parameter int RATE_W      = 16,
    parameter int WORD_BITS   = 24,
    parameter int SCLK_HALF   = 2,
    parameter int LATCH_CYC   = 4,
    localparam int NCH        = N_CHIPS * CH_PER_CHIP,
    localparam int CH_AW      = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               shuttle,
    input  logic [SET_AW-1:0]  first_set,
    input  logic [SET_AW-1:0]  last_set,
    input  logic [DW-1:0]      step_size,
    input  logic [RATE_W-1:0]  rate_div,
    output logic [SET_AW-1:0]  mem_set,
    output logic [CH_AW-1:0]   mem_chan,
    input  logic [DW-1:0]      mem_rdata,
    output logic               busy,
    output logic               sclk,
    output logic               latch,
    output logic [N_CHIPS-1:0] sdata
);
    seq_state_t        st;
    logic [SET_AW-1:0] set_q, end_q;
    logic [DW-1:0]     step_q;
    logic [RATE_W-1:0] rate_q, per_cnt;
    logic              mode_q, first_q, iss, v1, reach, go_q, tx_done;
    logic [CH_AW-1:0]  ch_q, wr_ch;
    logic [DW-1:0]     cur [NCH];
    logic [NCH*DW-1:0] vals;
    logic [DW-1:0]     cur_sel, nxt;
    logic              jump, at_tgt;

    assign cur_sel = cur[wr_ch];
    assign jump    = first_q || (step_q == '0);

    vsq_stepper #(.DW(DW)) u_step (
        .cur(cur_sel), .tgt(mem_rdata), .step(step_q), .jump(jump),
        .nxt(nxt), .at_tgt(at_tgt)
    );

    // Sequencing: capture, channel fetch pass, shift wait, period wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SQ_IDLE; set_q <= '0; end_q <= '0; step_q <= '0; rate_q <= '0;
            per_cnt <= '0; mode_q <= 1'b0; first_q <= 1'b0; iss <= 1'b0; v1 <= 1'b0;
            reach <= 1'b0; go_q <= 1'b0; ch_q <= '0; wr_ch <= '0;
            for (int i = 0; i < NCH; i++) cur[i] <= '0;
        end else begin
            go_q <= 1'b0;
            if (per_cnt != '1) per_cnt <= per_cnt + 1'b1;
            case (st)
                SQ_IDLE: if (start) begin
                    set_q <= first_set; end_q <= last_set; step_q <= step_size;
                    rate_q <= rate_div; mode_q <= shuttle; first_q <= 1'b1;
                    st <= SQ_FETCH; ch_q <= '0; iss <= 1'b1; reach <= 1'b1;
                    per_cnt <= RATE_W'(1);
                end
                SQ_FETCH: begin
                    v1    <= iss;
                    wr_ch <= ch_q;
                    if (iss) begin
                        if (ch_q == CH_AW'(NCH - 1)) iss <= 1'b0;
                        else ch_q <= ch_q + 1'b1;
                    end
                    if (v1) begin
                        cur[wr_ch] <= nxt;
                        reach <= reach && at_tgt;
                        if (wr_ch == CH_AW'(NCH - 1)) begin
                            st <= SQ_SHIFT; go_q <= 1'b1;
                        end
                    end
                end
                SQ_SHIFT: if (tx_done) begin
                    first_q <= 1'b0;
                    if (!mode_q || (reach && set_q >= end_q)) st <= SQ_IDLE;
                    else begin
                        if (reach) set_q <= set_q + 1'b1;
                        st <= SQ_WAIT;
                    end
                end
                SQ_WAIT: if (per_cnt >= rate_q) begin
                    st <= SQ_FETCH; ch_q <= '0; iss <= 1'b1; reach <= 1'b1;
                    per_cnt <= RATE_W'(1);
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Flatten the code bank for the shifter.
    for (genvar i = 0; i < NCH; i++) begin : g_flat
        assign vals[i*DW +: DW] = cur[i];
    end

    vsq_serial #(
        .N_CHIPS(N_CHIPS), .CH_PER_CHIP(CH_PER_CHIP), .DW(DW),
        .WORD_BITS(WORD_BITS), .SCLK_HALF(SCLK_HALF), .LATCH_CYC(LATCH_CYC)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .go(go_q), .vals(vals),
        .sclk(sclk), .latch(latch), .sdata(sdata), .done(tx_done)
    );

    assign mem_set  = set_q;
    assign mem_chan = ch_q;
    assign busy     = (st != SQ_IDLE);

    AST_IDLE_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk && !latch && sdata == '0);  // R11
    AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_FETCH && v1) |-> ((nxt >= cur_sel && nxt <= mem_rdata) ||
                                    (nxt <= cur_sel && nxt >= mem_rdata)));  // R7
    AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_FETCH && v1 && !jump && nxt != mem_rdata) |->
            ((nxt > cur_sel) ? (nxt - cur_sel) : (cur_sel - nxt)) == step_q);  // R6
    AST_SET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !first_q) |-> set_q <= end_q);  // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(end_q) && $stable(mode_q) && $stable(step_q));  // R12
endmodule

// File: tb/sim_vset_sequencer.sv
module sim_vset_sequencer;
    localparam int NCHIP = 25;
    localparam int NCH   = NCHIP * 4;
    localparam int FBITS = 96;
    localparam int MINSP = FBITS * 2 * 2;

    typedef struct packed {
        logic        mode;
        logic [4:0]  s;
        logic [4:0]  e;
        logic [15:0] step;
        logic [15:0] rate;
        logic [7:0]  tag;
    } vec_t;

    // mode, first, last, step, rate, requirement tag
    localparam vec_t VECS [6] = '{
        '{1'b0, 5'd1, 5'd0, 16'd0,     16'd1000, 8'd5},  // R5 static load
        '{1'b1, 5'd2, 5'd3, 16'd4096,  16'd700,  8'd7},  // R7 clamp onto all-ones
        '{1'b1, 5'd3, 5'd5, 16'd10000, 16'd700,  8'd6},  // R6 down to zeros then mixed
        '{1'b1, 5'd5, 5'd6, 16'd0,     16'd700,  8'd8},  // R8 jump
        '{1'b1, 5'd6, 5'd6, 16'd100,   16'd700,  8'd5},  // R5 single-set shuttle
        '{1'b1, 5'd7, 5'd8, 16'd20000, 16'd3,    8'd10}  // R10 minimum spacing
    };

    logic clk = 0, rst_n = 0, start = 0, shuttle = 0;
    logic [4:0] first_set = 0, last_set = 0;
    logic [15:0] step_size = 0, rate_div = 0;
    logic [4:0] mem_set;
    logic [6:0] mem_chan;
    logic [15:0] mem_rdata = 0;
    logic busy, sclk, latch;
    logic [NCHIP-1:0] sdata;

    int n_chk = 0, n_bad = 0;
    longint cyc = 0;

    vset_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .shuttle(shuttle),
        .first_set(first_set), .last_set(last_set), .step_size(step_size),
        .rate_div(rate_div), .mem_set(mem_set), .mem_chan(mem_chan),
        .mem_rdata(mem_rdata), .busy(busy), .sclk(sclk), .latch(latch), .sdata(sdata)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] memv(int s, int ch);
        logic [31:0] t;
        if (s == 3) return 16'hFFFF;
        if (s == 4) return 16'h0000;
        t = s * 9973 + ch * 613 + 77;
        return t[15:0];
    endfunction

    // Set memory model, one cycle read latency (R2)
    always @(posedge clk) begin
        mem_rdata <= memv(int'(mem_set), int'(mem_chan));
        cyc <= cyc + 1;
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            chk(0, "watchdog", "run did not finish", cyc, 150000);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // Reference model state
    logic [15:0] m_cur [NCH];
    int  m_set, m_end, m_frames, m_tag, m_rate, nbits, lat_hi, sclk_edges;
    logic [15:0] m_step;
    bit  m_static, m_first, m_done, lat_sclk_bad;
    longint prev_t;
    logic [FBITS-1:0] sh [NCHIP];
    logic sclk_q = 0, latch_q = 0;

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk != sclk_q) sclk_edges++;
            if (sclk && !sclk_q) begin
                for (int c = 0; c < NCHIP; c++) sh[c] = {sh[c][FBITS-2:0], sdata[c]};
                nbits++;
            end
            if (latch) begin
                lat_hi++;
                if (sclk) lat_sclk_bad = 1;
            end
            if (!latch && latch_q) begin
                chk(lat_hi == 4 && !lat_sclk_bad, "R4", "latch width with sclk low", lat_hi, 4);
                lat_hi = 0; lat_sclk_bad = 0;
            end
            if (latch && !latch_q) begin
                m_frames++;
                if (m_done) chk(0, "R12", "extra frame after run end", m_frames, m_frames - 1);
                else begin
                    bit reach, bad;
                    logic [23:0] got, exp;
                    reach = 1; bad = 0; got = 0; exp = 0;
                    for (int i = 0; i < NCH; i++) begin
                        logic [15:0] t;
                        t = memv(m_set, i);
                        if (m_first || m_step == 0) m_cur[i] = t;
                        else if (t > m_cur[i]) m_cur[i] = (t - m_cur[i] <= m_step) ? t : m_cur[i] + m_step;
                        else if (t < m_cur[i]) m_cur[i] = (m_cur[i] - t <= m_step) ? t : m_cur[i] - m_step;
                        if (m_cur[i] != t) reach = 0;
                    end
                    for (int c = 0; c < NCHIP; c++)
                        for (int w = 0; w < 4; w++) begin
                            logic [23:0] g, x;
                            g = sh[c][FBITS-1-24*w -: 24];
                            x = {6'b0, 2'(w), m_cur[c*4+w]};
                            if (g != x && !bad) begin bad = 1; got = g; exp = x; end
                        end
                    // first frame content also proves R2 addressing
                    chk(!bad, m_first ? "R2" : $sformatf("R%0d", m_tag), "frame words", got, exp);
                    chk(nbits == FBITS, "R3", "rising sclk edges per frame", nbits, FBITS);
                    if (prev_t >= 0) begin
                        if (m_rate >= MINSP + 200)
                            chk(cyc - prev_t == m_rate, "R10", "latch spacing", cyc - prev_t, m_rate);
                        else
                            chk(cyc - prev_t >= MINSP, "R10", "latch spacing floor", cyc - prev_t, MINSP);
                    end
                    prev_t = cyc;
                    m_first = 0;
                    if (m_static || (reach && m_set >= m_end)) m_done = 1;
                    else if (reach) m_set++;
                end
                nbits = 0;
            end
            sclk_q = sclk;
            latch_q = latch;
        end
    end

    task automatic run(vec_t v, bit dbl);
        @(negedge clk);
        shuttle = v.mode; first_set = v.s; last_set = v.e;
        step_size = v.step; rate_div = v.rate;
        m_set = int'(v.s); m_end = int'(v.e); m_step = v.step; m_rate = int'(v.rate);
        m_static = !v.mode; m_first = 1; m_done = 0; m_frames = 0; m_tag = int'(v.tag);
        prev_t = -1; nbits = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        if (dbl) begin
            repeat (150) @(negedge clk);
            first_set = 5'd9; shuttle = 1; last_set = 5'd12; step_size = 16'd1;
            start = 1;
            @(negedge clk);
            start = 0;
        end
        while (busy) @(negedge clk);
        chk(m_done, "R9", "run ended after final target frame", m_done, 1);
        if (m_static || v.e <= v.s)
            chk(m_frames == 1, dbl ? "R12" : "R5", "frames in single-set run", m_frames, 1);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !sclk && !latch && sdata == 0, "R1", "idle outputs in reset",
            {busy, sclk, latch}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !sclk && !latch && sdata == 0, "R1", "idle outputs after reset",
            {busy, sclk, latch}, 0);
        for (int k = 0; k < 6; k++) run(VECS[k], 1'b0);
        // R12: second start mid-frame during a static load
        run(VECS[0], 1'b1);
        // R11: clocks quiet while idle
        sclk_edges = 0;
        begin
            bit quiet;
            quiet = 1;
            for (int k = 0; k < 400; k++) begin
                @(negedge clk);
                if (latch || sdata != 0) quiet = 0;
            end
            chk(quiet && sclk_edges == 0, "R11", "sclk edges while idle", sclk_edges, 0);
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule